// File: doc/BRIEF.md
# Expansion Bus Clock Enable Generator

This block produces the clock-enable pulse train that paces an expansion bus from the fast host clock. A three-bit select field picks the rate. Six codes divide the host clock by an integer ratio, and these ratios include odd values. The two remaining codes choose a slow fixed reference, which arrives as a one-cycle tick input that is already synchronised to the host clock. The enable is high for one host clock per bus period. Downstream bus logic qualifies its registers with this enable.

The block also reports the divide ratio in force, which serves as a nominal-frequency status. A value of zero means the fixed reference is driving the enable. A new select value is picked up only at the end of the period that is running, so the pulse train never contains a short period. The value at the moment of a pulse decides the rate that follows it. A change made in the middle of a period is therefore not seen until that period ends.

Top module: `busclk_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `bus_ce_o` is 0 and `ratio_o` is 0. The block leaves reset in fixed-reference mode.
- R2: Select codes map to divide ratios as follows: 3'b001 gives 4, 3'b010 gives 5, 3'b011 gives 6, 3'b100 gives 8, 3'b101 gives 10 and 3'b110 gives 12. Once a ratio N is in force, `ratio_o` equals N and consecutive enable pulses are exactly N host clocks apart.
- R3: Select 3'b000 puts the block in fixed-reference mode, and `ratio_o` reads 0. Each cycle in which `ref_tick_i` is 1 produces an enable pulse in the following cycle.
- R4: Select 3'b111 is treated exactly like 3'b000: fixed-reference mode with `ratio_o` at 0.
- R5: The select value is sampled only at the end of a bus period, which is a divider terminal count or, in fixed-reference mode, a reference tick. `ratio_o` changes only in a cycle where `bus_ce_o` is 1, and the period that is running keeps its old length.
- R6: In divide mode `bus_ce_o` is high for exactly one host clock per period.
- R7: In divide mode `ref_tick_i` has no effect on the spacing of the pulses.
- R8: In fixed-reference mode no enable pulse appears unless a reference tick has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 3 | Bus rate select code |
| ref_tick_i | input | 1 | One-cycle fixed-reference tick, synchronous to clk |
| bus_ce_o | output | 1 | Bus clock enable, one host clock wide |
| ratio_o | output | 4 | Divide ratio in force; 0 in fixed-reference mode |

## Verification
The enable is registered, so a reference tick seen in cycle t shows up as a pulse in cycle t+1. A divider terminal count behaves the same way. `ratio_o` changes in the same cycle as the pulse that closes the old period. After a select change, the bench first waits for that closing pulse and reads `ratio_o` there. It then counts host clocks up to the next pulse and compares the count with the ratio. In fixed-reference mode it raises the tick for one cycle and expects the pulse at the very next sample, with the enable low again one sample later. All inputs are driven, and all outputs are sampled, on the falling edge.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
   localparam int unsigned SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_REF0  = 3'b000,
      SEL_DIVA  = 3'b001,
      SEL_DIVB  = 3'b010,
      SEL_DIVC  = 3'b011,
      SEL_DIVD  = 3'b100,
      SEL_DIVE  = 3'b101,
      SEL_DIVF  = 3'b110,
      SEL_REF1  = 3'b111
   } bus_sel_e;
endpackage

// File: rtl/busclk_decode.sv
module busclk_decode #(
   parameter int unsigned RATIO_W = 4,
   parameter int unsigned DIV_A   = 4,
   parameter int unsigned DIV_B   = 5,
   parameter int unsigned DIV_C   = 6,
   parameter int unsigned DIV_D   = 8,
   parameter int unsigned DIV_E   = 10,
   parameter int unsigned DIV_F   = 12
) (
   input  logic [busclk_pkg::SEL_W-1:0] sel_i,
   output logic [RATIO_W-1:0]           ratio_o
);
   import busclk_pkg::*;

   always_comb begin
      unique case (bus_sel_e'(sel_i))
         SEL_DIVA: ratio_o = RATIO_W'(DIV_A);
         SEL_DIVB: ratio_o = RATIO_W'(DIV_B);
         SEL_DIVC: ratio_o = RATIO_W'(DIV_C);
         SEL_DIVD: ratio_o = RATIO_W'(DIV_D);
         SEL_DIVE: ratio_o = RATIO_W'(DIV_E);
         SEL_DIVF: ratio_o = RATIO_W'(DIV_F);
         default:  ratio_o = '0;
      endcase
   end
endmodule

// File: rtl/busclk_divider.sv
module busclk_divider #(
   parameter int unsigned RATIO_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_tick_i,
   input  logic [RATIO_W-1:0] next_ratio_i,
   output logic               tc_o,
   output logic [RATIO_W-1:0] ratio_o
);
   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] ratio_q;
   logic               ref_mode;
   logic [RATIO_W-1:0] last_cnt;

   assign ref_mode = (ratio_q == '0);
   assign last_cnt = ratio_q - RATIO_W'(1);
   assign tc_o     = ref_mode ? ref_tick_i : (cnt_q == last_cnt);
   assign ratio_o  = ratio_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ratio_q <= '0;
      end else if (tc_o) begin
         cnt_q   <= '0;
         ratio_q <= next_ratio_i;
      end else if (!ref_mode) begin
         cnt_q   <= cnt_q + RATIO_W'(1);
      end
   end
endmodule

// File: rtl/busclk_pulse.sv
module busclk_pulse #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tc_i,
   output logic ce_o
);
   generate
      if (OUT_REG) begin : g_reg
         logic ce_q;
         always_ff @(posedge clk) begin
            if (!rst_n) ce_q <= 1'b0;
            else        ce_q <= tc_i;
         end
         assign ce_o = ce_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk;
         assign ce_o = tc_i & rst_n;
      end
   endgenerate
endmodule

// File: rtl/busclk_gen.sv
module busclk_gen #(
   parameter int unsigned RATIO_W = 4,
   parameter int unsigned DIV_A   = 4,
   parameter int unsigned DIV_B   = 5,
   parameter int unsigned DIV_C   = 6,
   parameter int unsigned DIV_D   = 8,
   parameter int unsigned DIV_E   = 10,
   parameter int unsigned DIV_F   = 12,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [busclk_pkg::SEL_W-1:0]  sel_i,
   input  logic                          ref_tick_i,
   output logic                          bus_ce_o,
   output logic [RATIO_W-1:0]            ratio_o
);
   localparam int unsigned MAX_RATIO = (1 << RATIO_W) - 1;

   generate
      if (DIV_A < 2 || DIV_B < 2 || DIV_C < 2 ||
          DIV_D < 2 || DIV_E < 2 || DIV_F < 2) begin : g_bad_min
         $error("busclk_gen: every divide ratio must be at least 2");
      end
      if (DIV_A > MAX_RATIO || DIV_B > MAX_RATIO || DIV_C > MAX_RATIO ||
          DIV_D > MAX_RATIO || DIV_E > MAX_RATIO || DIV_F > MAX_RATIO) begin : g_bad_max
         $error("busclk_gen: a divide ratio does not fit RATIO_W");
      end
   endgenerate

   logic [RATIO_W-1:0] next_ratio;
   logic               tc;

   busclk_decode #(
      .RATIO_W (RATIO_W),
      .DIV_A   (DIV_A),
      .DIV_B   (DIV_B),
      .DIV_C   (DIV_C),
      .DIV_D   (DIV_D),
      .DIV_E   (DIV_E),
      .DIV_F   (DIV_F)
   ) u_dec (
      .sel_i   (sel_i),
      .ratio_o (next_ratio)
   );

   busclk_divider #(
      .RATIO_W (RATIO_W)
   ) u_div (
      .clk          (clk),
      .rst_n        (rst_n),
      .ref_tick_i   (ref_tick_i),
      .next_ratio_i (next_ratio),
      .tc_o         (tc),
      .ratio_o      (ratio_o)
   );

   busclk_pulse #(
      .OUT_REG (OUT_REG)
   ) u_pls (
      .clk   (clk),
      .rst_n (rst_n),
      .tc_i  (tc),
      .ce_o  (bus_ce_o)
   );
endmodule

// File: rtl/busclk_gen_chk.sv
module busclk_gen_chk #(
   parameter int unsigned RATIO_W = 4,
   parameter int unsigned DIV_A   = 4,
   parameter int unsigned DIV_B   = 5,
   parameter int unsigned DIV_C   = 6,
   parameter int unsigned DIV_D   = 8,
   parameter int unsigned DIV_E   = 10,
   parameter int unsigned DIV_F   = 12,
   parameter bit          OUT_REG = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ref_tick_i,
   input logic               bus_ce_o,
   input logic [RATIO_W-1:0] ratio_o
);
   logic [RATIO_W:0]   gap_q;
   logic [RATIO_W-1:0] last_q;
   logic               seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= '0;
         last_q <= '0;
         seen_q <= 1'b0;
      end else if (bus_ce_o) begin
         gap_q  <= (RATIO_W+1)'(1);
         last_q <= ratio_o;
         seen_q <= 1'b1;
      end else if (gap_q != '1) begin
         gap_q  <= gap_q + (RATIO_W+1)'(1);
      end
   end

   // R2: pulse spacing equals the ratio that was in force for the period
   a_r2_period: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ce_o && seen_q && last_q != '0) |-> (gap_q == {1'b0, last_q}));

   // R2, R4: status only takes a legal value
   a_r2_legal_ratio: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_o == '0 || ratio_o == RATIO_W'(DIV_A) || ratio_o == RATIO_W'(DIV_B) ||
       ratio_o == RATIO_W'(DIV_C) || ratio_o == RATIO_W'(DIV_D) ||
       ratio_o == RATIO_W'(DIV_E) || ratio_o == RATIO_W'(DIV_F)));

   // R6: one host clock wide in divide mode
   a_r6_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ce_o && ratio_o != '0) |=> !bus_ce_o);

   generate
      if (OUT_REG) begin : g_reg_props
         // R3, R8: in reference mode the enable mirrors the previous tick
         a_r3_ref_follow: assert property (@(posedge clk) disable iff (!rst_n)
            (ratio_o == '0) |=> (bus_ce_o == $past(ref_tick_i)));

         // R5: the ratio moves only together with a pulse
         a_r5_switch_at_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(ratio_o) |-> bus_ce_o);
      end
   endgenerate
endmodule

bind busclk_gen busclk_gen_chk #(
   .RATIO_W (RATIO_W),
   .DIV_A   (DIV_A),
   .DIV_B   (DIV_B),
   .DIV_C   (DIV_C),
   .DIV_D   (DIV_D),
   .DIV_E   (DIV_E),
   .DIV_F   (DIV_F),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_tick_i (ref_tick_i),
   .bus_ce_o   (bus_ce_o),
   .ratio_o    (ratio_o)
);

// File: tb/sim_busclk_gen.sv
module sim_busclk_gen;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 10;
   localparam int WATCHDOG   = 20000;

   // each entry: {select code, expected ratio}
   localparam logic [6:0] VEC [NVEC] = '{
      {3'b001, 4'd4},  {3'b010, 4'd5},  {3'b000, 4'd0}, {3'b011, 4'd6},
      {3'b100, 4'd8},  {3'b111, 4'd0},  {3'b101, 4'd10}, {3'b110, 4'd12},
      {3'b000, 4'd0},  {3'b001, 4'd4}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] sel_i = 3'b000;
   logic       ref_tick_i = 1'b0;
   logic       bus_ce_o;
   logic [3:0] ratio_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   busclk_gen u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (sel_i),
      .ref_tick_i (ref_tick_i),
      .bus_ce_o   (bus_ce_o),
      .ratio_o    (ratio_o)
   );

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // reach the pulse that closes the current period
   task automatic close_period();
      if (ratio_o == 4'd0) begin
         ref_tick_i = 1'b1;
         tick();
         ref_tick_i = 1'b0;
      end else begin
         do tick(); while (!bus_ce_o);
      end
   endtask

   // count host clocks up to the next pulse
   task automatic period_len(output int n);
      n = 0;
      do begin
         tick();
         n++;
      end while (!bus_ce_o && n < 100);
   endtask

   initial begin
      int n;
      int seen;
      sel_i = 3'b010;
      repeat (3) tick();
      check("R1 ce in reset", int'(bus_ce_o), 0);
      check("R1 ratio in reset", int'(ratio_o), 0);
      rst_n = 1'b1;
      tick();
      check("R1 ce after reset", int'(bus_ce_o), 0);
      check("R1 ratio after reset", int'(ratio_o), 0);

      for (int i = 0; i < NVEC; i++) begin
         sel_i = VEC[i][6:4];
         close_period();
         check($sformatf("R2/R3/R4/R5 ratio sel=%b", VEC[i][6:4]), int'(ratio_o), int'(VEC[i][3:0]));
         if (VEC[i][3:0] != 4'd0) begin
            ref_tick_i = (i % 2 == 0);   // R7: tick level must not matter
            period_len(n);
            ref_tick_i = 1'b0;
            check($sformatf("R2/R7 period sel=%b", VEC[i][6:4]), n, int'(VEC[i][3:0]));
         end else begin
            seen = 0;
            tick();
            repeat (15) begin
               tick();
               if (bus_ce_o) seen++;
            end
            check("R8 no pulse without tick", seen, 0);
            ref_tick_i = 1'b1;
            tick();
            ref_tick_i = 1'b0;
            check("R3 pulse after tick", int'(bus_ce_o), 1);
            tick();
            check("R3 pulse one wide", int'(bus_ce_o), 0);
         end
      end

      // R5: mid-period change, current period keeps the old ratio
      sel_i = 3'b110;
      close_period();
      check("R5 ratio 12", int'(ratio_o), 12);
      tick();
      check("R6 pulse low after one clock", int'(bus_ce_o), 0);
      sel_i = 3'b001;
      repeat (3) tick();
      sel_i = 3'b011;
      n = 4;
      do begin
         tick();
         n++;
      end while (!bus_ce_o && n < 100);
      check("R5 old period length kept", n, 12);
      check("R5 new ratio at pulse", int'(ratio_o), 6);
      period_len(n);
      check("R5 new period length", n, 6);

      finish_run();
   end
endmodule